// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block holds two single-word mail registers that let two agents on separate clocks pass one word at a time to each other without going through the bulk queue. The first mailbox carries a word from the port-A side to the port-B side. The second carries a word from port B back to port A. Each mailbox has an active-low full flag in the clock domain of its writer. The writer may load a new word only while that flag is high. Once the word has been loaded, the flag stays low until the reader on the other clock has consumed it.

Each port has a mailbox-select input. When it is high, an access goes to the mailbox. When it is low, the access is handed to the bulk queue as a strobe. The queue itself lives outside this block. On port B the same select also steers the output word. It shows the first mailbox when high and the queue's output register when low.

Internally each mailbox is a one-deep toggle handshake:

- The writer flips a toggle bit when it loads a word.
- The reader sees that toggle through a chain of synchronizing flops and raises a ready indication.
- A read flips an acknowledge toggle, which travels back through a second synchronizer and releases the full flag.
- The data word stays in the writer's register from the load until the release. The reader therefore samples a word that does not change.

Top module: `mbox_pair`

## Requirements
- R1: While `rstN` is low, and after it is released, both full flags (`mail1FullN`, `mail2FullN`) are 1, both ready outputs are 0, and both mail words read as zero.
- R2: A port-A access is a rising `clkA` edge with `csAN`=0 and `enA`=1. If that access has `writeA`=1 and `mbSelA`=1 while `mail1FullN`=1, the word on `dataInA` is stored in the first mailbox. `mail1FullN` is 0 right after that edge.
- R3: A write to a mailbox whose full flag is 0 is ignored: the stored word does not change.
- R4: `mail1ReadyB` goes to 1 after the SYNC_STAGES-th rising `clkB` edge that follows the loading edge (the second edge with defaults). A port-B mailbox read made before then has no effect.
- R5: A port-B access is a rising `clkB` edge with `csBN`=0 and `enB`=1. If that access has `writeB`=0 and `mbSelB`=1 while `mail1ReadyB`=1, `mail1ReadyB` is 0 after that edge. `mail1FullN` returns to 1 after the SYNC_STAGES-th following rising `clkA` edge.
- R6: The second mailbox follows R2 to R5 with the ports swapped:
  - a port-B write with `mbSelB`=1 loads it from `dataInB` and drives `mail2FullN` low;
  - `mail2ReadyA` signals a waiting word to port A;
  - a port-A read with `mbSelA`=1 releases it.
- R7: `dataOutB` equals the first mailbox word when `mbSelB`=1 and `fifoDataB` when `mbSelB`=0.
- R8: An edge with the chip select high or the enable low is not an access. It changes no flag, ready output or mail word.
- R9: `fifoWrEnA` is 1 exactly when a port-A access writes with `mbSelA`=0. `fifoRdEnB` is 1 exactly when a port-B access reads with `mbSelB`=0.
- R10: `dataOutA` always shows the word stored in the second mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port-A clock |
| clkB | input | 1 | Port-B clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| csAN | input | 1 | Port-A chip select, active low |
| enA | input | 1 | Port-A enable, active high |
| writeA | input | 1 | Port-A direction: 1 write, 0 read |
| mbSelA | input | 1 | Port-A mailbox select: 1 mailbox, 0 queue |
| dataInA | input | DATA_W | Port-A write word |
| dataOutA | output | DATA_W | Word held in the second mailbox |
| mail1FullN | output | 1 | First mailbox full flag, active low, clkA domain |
| mail2ReadyA | output | 1 | Second mailbox holds an unread word, clkA domain |
| fifoWrEnA | output | 1 | Queue write strobe from port A |
| csBN | input | 1 | Port-B chip select, active low |
| enB | input | 1 | Port-B enable, active high |
| writeB | input | 1 | Port-B direction: 1 write, 0 read |
| mbSelB | input | 1 | Port-B mailbox select and output steering |
| dataInB | input | DATA_W | Port-B write word |
| fifoDataB | input | DATA_W | Queue output register word |
| dataOutB | output | DATA_W | First mailbox word or queue word |
| mail2FullN | output | 1 | Second mailbox full flag, active low, clkB domain |
| mail1ReadyB | output | 1 | First mailbox holds an unread word, clkB domain |
| fifoRdEnB | output | 1 | Queue read strobe from port B |

## Verification
The bench builds the block with DATA_W=36 and SYNC_STAGES=2, and drives both clocks from one coincident source. Under coincident clocks the handshake latency is an exact cycle count. That lets the bench's model predict the cycle in which each ready output rises and each full flag releases.

With only two synchronizer stages, a word makes its full round trip in a handful of cycles. Random traffic therefore reaches these cases many times:
- reads made too early;
- writes blocked by a low flag;
- reads and writes that land on the same edge in both directions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Strobes produced by a port's access decoder for the datapath.
  typedef struct packed {
    logic mbLoad;   // accepted write into the port's outgoing mailbox
    logic mbAck;    // accepted read of the port's incoming mailbox
    logic fifoAcc;  // access handed to the bulk queue
  } portStrobe_t;

endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mbox_port_ctrl.sv
module mbox_port_ctrl
  import mbox_pkg::*;
#(
  parameter bit FIFO_IS_WRITE = 1'b1
) (
  input  logic        csN,
  input  logic        en,
  input  logic        write,
  input  logic        mbSel,
  input  logic        ownFree,
  input  logic        peerReady,
  output portStrobe_t stb
);

  logic access;

  assign access = !csN && en;

  always_comb begin
    stb         = '0;
    stb.mbLoad  = access && write && mbSel && ownFree;
    stb.mbAck   = access && !write && mbSel && peerReady;
    stb.fifoAcc = access && !mbSel && (write == FIFO_IS_WRITE);
  end

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkW,
  input  logic              clkR,
  input  logic              rstN,
  input  logic              load,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ack,
  output logic              fullN,
  output logic              ready,
  output logic [DATA_W-1:0] mailData
);

  // Writer domain
  logic              wrTgl;
  logic              ackSyncW;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clkW or negedge rstN) begin
    if (!rstN) begin
      wrTgl <= 1'b0;
      dataQ <= '0;
    end else if (load) begin
      wrTgl <= ~wrTgl;
      dataQ <= dataIn;
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) ackSync_i (
    .clk  (clkW),
    .rstN (rstN),
    .d    (ackTgl),
    .q    (ackSyncW)
  );

  // Reader domain
  logic ackTgl;
  logic wrSyncR;

  always_ff @(posedge clkR or negedge rstN) begin
    if (!rstN) begin
      ackTgl <= 1'b0;
    end else if (ack) begin
      ackTgl <= ~ackTgl;
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) wrSync_i (
    .clk  (clkR),
    .rstN (rstN),
    .d    (wrTgl),
    .q    (wrSyncR)
  );

  assign fullN    = ~(wrTgl ^ ackSyncW);
  assign ready    = wrSyncR ^ ackTgl;
  assign mailData = dataQ;

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              csAN,
  input  logic              enA,
  input  logic              writeA,
  input  logic              mbSelA,
  input  logic [DATA_W-1:0] dataInA,
  output logic [DATA_W-1:0] dataOutA,
  output logic              mail1FullN,
  output logic              mail2ReadyA,
  output logic              fifoWrEnA,
  input  logic              csBN,
  input  logic              enB,
  input  logic              writeB,
  input  logic              mbSelB,
  input  logic [DATA_W-1:0] dataInB,
  input  logic [DATA_W-1:0] fifoDataB,
  output logic [DATA_W-1:0] dataOutB,
  output logic              mail2FullN,
  output logic              mail1ReadyB,
  output logic              fifoRdEnB
);

  portStrobe_t       stbA;
  portStrobe_t       stbB;
  logic [DATA_W-1:0] mail1Data;
  logic [DATA_W-1:0] mail2Data;

  mbox_port_ctrl #(.FIFO_IS_WRITE(1'b1)) ctrlA_i (
    .csN       (csAN),
    .en        (enA),
    .write     (writeA),
    .mbSel     (mbSelA),
    .ownFree   (mail1FullN),
    .peerReady (mail2ReadyA),
    .stb       (stbA)
  );

  mbox_port_ctrl #(.FIFO_IS_WRITE(1'b0)) ctrlB_i (
    .csN       (csBN),
    .en        (enB),
    .write     (writeB),
    .mbSel     (mbSelB),
    .ownFree   (mail2FullN),
    .peerReady (mail1ReadyB),
    .stb       (stbB)
  );

  // A to B
  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) mail1_i (
    .clkW     (clkA),
    .clkR     (clkB),
    .rstN     (rstN),
    .load     (stbA.mbLoad),
    .dataIn   (dataInA),
    .ack      (stbB.mbAck),
    .fullN    (mail1FullN),
    .ready    (mail1ReadyB),
    .mailData (mail1Data)
  );

  // B to A
  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) mail2_i (
    .clkW     (clkB),
    .clkR     (clkA),
    .rstN     (rstN),
    .load     (stbB.mbLoad),
    .dataIn   (dataInB),
    .ack      (stbA.mbAck),
    .fullN    (mail2FullN),
    .ready    (mail2ReadyA),
    .mailData (mail2Data)
  );

  assign dataOutA  = mail2Data;
  assign dataOutB  = mbSelB ? mail1Data : fifoDataB;
  assign fifoWrEnA = stbA.fifoAcc;
  assign fifoRdEnB = stbB.fifoAcc;

endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int DATA_W = 36
) (
  input logic              clkA,
  input logic              clkB,
  input logic              rstN,
  input logic              csAN,
  input logic              enA,
  input logic              writeA,
  input logic              mbSelA,
  input logic [DATA_W-1:0] dataInA,
  input logic              mail1FullN,
  input logic              mail2ReadyA,
  input logic              csBN,
  input logic              enB,
  input logic              writeB,
  input logic              mbSelB,
  input logic [DATA_W-1:0] dataInB,
  input logic              mail2FullN,
  input logic              mail1ReadyB,
  input logic [DATA_W-1:0] mail1Data,
  input logic [DATA_W-1:0] mail2Data
);

  // Port-A clock domain
  assert_load_sets_flag_R2: assert property (@(posedge clkA) disable iff (!rstN)
    (!csAN && enA && writeA && mbSelA && mail1FullN)
      |=> (!mail1FullN && mail1Data == $past(dataInA)));

  assert_locked_word_R3: assert property (@(posedge clkA) disable iff (!rstN)
    !mail1FullN |=> $stable(mail1Data));

  assert_gated_access_R8: assert property (@(posedge clkA) disable iff (!rstN)
    ((csAN || !enA) && mail1FullN) |=> mail1FullN);

  assert_mail2_ack_R6: assert property (@(posedge clkA) disable iff (!rstN)
    (!csAN && enA && !writeA && mbSelA && mail2ReadyA) |=> !mail2ReadyA);

  assert_mail2_ready_full_R6: assert property (@(posedge clkA) disable iff (!rstN)
    mail2ReadyA |-> !mail2FullN);

  // Port-B clock domain
  assert_ready_needs_full_R4: assert property (@(posedge clkB) disable iff (!rstN)
    mail1ReadyB |-> !mail1FullN);

  assert_ack_clears_ready_R5: assert property (@(posedge clkB) disable iff (!rstN)
    (!csBN && enB && !writeB && mbSelB && mail1ReadyB) |=> !mail1ReadyB);

  assert_mail2_load_R6: assert property (@(posedge clkB) disable iff (!rstN)
    (!csBN && enB && writeB && mbSelB && mail2FullN)
      |=> (!mail2FullN && mail2Data == $past(dataInB)));

  assert_mail2_locked_R6: assert property (@(posedge clkB) disable iff (!rstN)
    !mail2FullN |=> $stable(mail2Data));

endmodule

bind mbox_pair mbox_pair_chk #(.DATA_W(DATA_W)) chk_i (
  .clkA        (clkA),
  .clkB        (clkB),
  .rstN        (rstN),
  .csAN        (csAN),
  .enA         (enA),
  .writeA      (writeA),
  .mbSelA      (mbSelA),
  .dataInA     (dataInA),
  .mail1FullN  (mail1FullN),
  .mail2ReadyA (mail2ReadyA),
  .csBN        (csBN),
  .enB         (enB),
  .writeB      (writeB),
  .mbSelB      (mbSelB),
  .dataInB     (dataInB),
  .mail2FullN  (mail2FullN),
  .mail1ReadyB (mail1ReadyB),
  .mail1Data   (mail1Data),
  .mail2Data   (mail2Data)
);

// File: tb/mbox_pair_tb_top.sv
module mbox_pair_tb_top;

  localparam int DW          = 36;
  localparam int SYNC        = 2;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN;
  logic          csAN, enA, writeA, mbSelA;
  logic [DW-1:0] dataInA, dataOutA;
  logic          mail1FullN, mail2ReadyA, fifoWrEnA;
  logic          csBN, enB, writeB, mbSelB;
  logic [DW-1:0] dataInB, fifoDataB, dataOutB;
  logic          mail2FullN, mail1ReadyB, fifoRdEnB;

  mbox_pair #(.DATA_W(DW), .SYNC_STAGES(SYNC)) dut_i (
    .clkA(clk), .clkB(clk), .rstN(rstN),
    .csAN(csAN), .enA(enA), .writeA(writeA), .mbSelA(mbSelA),
    .dataInA(dataInA), .dataOutA(dataOutA), .mail1FullN(mail1FullN),
    .mail2ReadyA(mail2ReadyA), .fifoWrEnA(fifoWrEnA),
    .csBN(csBN), .enB(enB), .writeB(writeB), .mbSelB(mbSelB),
    .dataInB(dataInB), .fifoDataB(fifoDataB), .dataOutB(dataOutB),
    .mail2FullN(mail2FullN), .mail1ReadyB(mail1ReadyB), .fifoRdEnB(fifoRdEnB)
  );

  int  vecCount = 0;
  int  errCount = 0;
  bit  done     = 1'b0;

  // Requirement model: index 0 = A-to-B mailbox, index 1 = B-to-A mailbox
  bit          mFull[2];
  bit          mPend[2];
  int          mVis[2];
  int          mRel[2];
  logic [DW-1:0] mData[2];

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    bit accA = !csAN && enA;
    bit accB = !csBN && enB;
    check("R2", "mail1FullN", DW'(mail1FullN), DW'(!mFull[0]));
    check("R4", "mail1ReadyB", DW'(mail1ReadyB), DW'(mPend[0]));
    check("R6", "mail2FullN", DW'(mail2FullN), DW'(!mFull[1]));
    check("R6", "mail2ReadyA", DW'(mail2ReadyA), DW'(mPend[1]));
    check("R7", "dataOutB", dataOutB, mbSelB ? mData[0] : fifoDataB);
    check("R10", "dataOutA", dataOutA, mData[1]);
    check("R9", "fifoWrEnA", DW'(fifoWrEnA), DW'(accA && writeA && !mbSelA));
    check("R9", "fifoRdEnB", DW'(fifoRdEnB), DW'(accB && !writeB && !mbSelB));
  endtask

  task automatic modelEdge();
    bit          wAcc[2];
    bit          rAcc[2];
    logic [DW-1:0] din[2];
    wAcc[0] = !csAN && enA && writeA && mbSelA;
    rAcc[0] = !csBN && enB && !writeB && mbSelB;
    din[0]  = dataInA;
    wAcc[1] = !csBN && enB && writeB && mbSelB;
    rAcc[1] = !csAN && enA && !writeA && mbSelA;
    din[1]  = dataInB;
    for (int i = 0; i < 2; i++) begin
      bit ld;
      bit ak;
      ld = wAcc[i] && !mFull[i];
      ak = rAcc[i] && mPend[i];
      if (mVis[i] > 0) begin
        mVis[i]--;
        if (mVis[i] == 0) mPend[i] = 1'b1;
      end
      if (mRel[i] > 0) begin
        mRel[i]--;
        if (mRel[i] == 0) mFull[i] = 1'b0;
      end
      if (ld) begin
        mFull[i] = 1'b1;
        mVis[i]  = SYNC;
        mData[i] = din[i];
      end
      if (ak) begin
        mPend[i] = 1'b0;
        mRel[i]  = SYNC;
      end
    end
  endtask

  task automatic tick();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  task automatic setA(bit cs_n, bit en, bit wr, bit sel, logic [DW-1:0] d);
    csAN = cs_n; enA = en; writeA = wr; mbSelA = sel; dataInA = d;
  endtask

  task automatic setB(bit cs_n, bit en, bit wr, bit sel, logic [DW-1:0] d, logic [DW-1:0] f);
    csBN = cs_n; enB = en; writeB = wr; mbSelB = sel; dataInB = d; fifoDataB = f;
  endtask

  function automatic logic [DW-1:0] rndWord();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d1, d2, d3, f0;
    void'($urandom(32'h5EED_0042));
    d1 = 36'h1_2345_6789;
    d2 = 36'hA_BCDE_F012;
    d3 = 36'h5_A5A5_A5A5;
    f0 = 36'h0_0F0F_F0F0;
    for (int i = 0; i < 2; i++) begin
      mFull[i] = 0; mPend[i] = 0; mVis[i] = 0; mRel[i] = 0; mData[i] = '0;
    end
    rstN = 1'b0;
    setA(1, 0, 0, 0, '0);
    setB(1, 0, 0, 1, '0, f0);
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check("R1", "mail1FullN in reset", DW'(mail1FullN), DW'(1));
    check("R1", "mail2FullN in reset", DW'(mail2FullN), DW'(1));
    check("R1", "dataOutB in reset", dataOutB, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll();
    check("R1", "ready outputs after reset", DW'({mail1ReadyB, mail2ReadyA}), '0);

    // R2: load first mailbox
    setA(0, 1, 1, 1, d1);
    tick();
    check("R2", "flag low after load", DW'(mail1FullN), DW'(0));
    check("R2", "stored word", dataOutB, d1);

    // R3 overwrite attempt, R4 early read ignored
    setA(0, 1, 1, 1, d2);
    setB(0, 1, 0, 1, '0, f0);
    tick();
    check("R3", "word unchanged by blocked write", dataOutB, d1);
    check("R4", "ready not yet raised", DW'(mail1ReadyB), DW'(0));
    setA(1, 0, 0, 0, '0);
    setB(1, 0, 0, 1, '0, f0);
    tick();
    check("R4", "ready after second clkB edge", DW'(mail1ReadyB), DW'(1));

    // R8: gated read does nothing
    setB(1, 1, 0, 1, '0, f0);
    tick();
    check("R8", "ready kept after gated read", DW'(mail1ReadyB), DW'(1));
    setB(0, 0, 0, 1, '0, f0);
    tick();
    check("R8", "ready kept with enable low", DW'(mail1ReadyB), DW'(1));

    // R5: real read and release timing
    setB(0, 1, 0, 1, '0, f0);
    tick();
    check("R5", "ready cleared by read", DW'(mail1ReadyB), DW'(0));
    setB(1, 0, 0, 0, '0, f0);
    tick();
    check("R5", "flag still low one cycle after read", DW'(mail1FullN), DW'(0));
    check("R7", "queue word shown when select low", dataOutB, f0);
    tick();
    check("R5", "flag released after second clkA edge", DW'(mail1FullN), DW'(1));

    // R6 / R10: second mailbox round trip
    setB(0, 1, 1, 1, d3, f0);
    tick();
    check("R6", "mail2 flag low after load", DW'(mail2FullN), DW'(0));
    check("R10", "dataOutA shows mail2 word", dataOutA, d3);
    setB(1, 0, 0, 0, '0, f0);
    tick();
    tick();
    check("R6", "mail2 ready on port A", DW'(mail2ReadyA), DW'(1));
    setA(0, 1, 0, 1, '0);
    tick();
    setA(1, 0, 0, 0, '0);
    tick();
    tick();
    check("R6", "mail2 flag released", DW'(mail2FullN), DW'(1));

    // Random traffic against the model
    for (int n = 0; n < RAND_CYCLES; n++) begin
      setA($urandom_range(3) == 0, $urandom_range(3) != 0, $urandom_range(1),
           $urandom_range(4) != 0, rndWord());
      setB($urandom_range(3) == 0, $urandom_range(3) != 0, $urandom_range(1),
           $urandom_range(4) != 0, rndWord(), rndWord());
      tick();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule